// File: doc/BRIEF.md
# Serial-Link Root-Port Bring-up Sequencer

This block steps a serial-link root-port controller and its PHY from power-down to a trained link. A single start pulse launches a fixed programme. First the block holds the PHY in test power-down, forces link training on, drops the reference clock and pulses the endpoint reset. It then loads the static PHY and transmitter settings. Next it brings power, the reference clock and a bank of clock enables up one at a time. It waits for the clocks to settle, enables training and polls the link-up indication until the link comes up or the poll budget runs out.

All time intervals are counted in microsecond ticks supplied by the system, so the block runs in any clock domain. A clock generator that reports an error while being enabled makes the block switch off every clock it has turned on, newest first, and finish with a clock error. A link that never comes up ends with a link error and a frozen copy of a debug word. The block can be started again from its idle, done or fail state.

Top module: `link_bringup_seq`

## Requirements
- R1: After an accepted start, on successive cycles the PHY test power-down goes high, then the training enable goes high, then the reference-clock enable goes low, then the endpoint reset goes low. The endpoint reset stays low until EP_RST_US ticks have been counted and then returns high. All clock enables are cleared on the cycle the start is accepted.
- R2: Once the endpoint reset is released, the training enable is cleared. On the next cycle the static settings are driven: device type 4 (root port), loss-of-signal level 9, gen1 de-emphasis 0, gen2 3.5 dB de-emphasis 0, gen2 6 dB de-emphasis 20, full swing 127, low swing 127. All of these are 0 from reset until they are first loaded.
- R3: After the settings are loaded, on successive cycles slot power rises (when HAS_SLOT_PWR is 1), then test power-down is cleared, then the reference clock is enabled.
- R4: Clock enables rise in index order 0 to NCLK-1 (index 0 is the 100 MHz reference, 1 the 125 MHz reference, 2 the output gate, 3 the bus clock). Each enable is followed by one cycle in which that clock's error input is sampled.
- R5: The training enable is set again only after SETTLE_US ticks have been counted, starting after the last clock enable has checked clean.
- R6: Link-up is sampled once every POLL_US ticks while training. When link-up is seen, done rises, busy falls and all outputs hold.
- R7: If link-up is absent at MAX_POLLS consecutive polls, fail rises with error code 2 and the debug input is captured into the snapshot output on the same cycle.
- R8: If a clock's error input is high at its check, that clock and every lower-index clock are switched off, one per cycle, newest first. The failing index is reported, and fail rises with error code 1 on the cycle the last clock goes off. Training stays disabled.
- R9: Start is ignored while busy. It is accepted in the idle, done and fail states, and accepting it clears done, fail and the error code.
- R10: Reset leaves power-down high, the reference clock off, endpoint reset high, slot power, clocks and training off, and no status.
- R11: Done and fail are never high together, and busy is high exactly between an accepted start and the cycle done or fail rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up programme |
| link_up | input | 1 | Link-up indication from the training logic |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| clk_err | input | NCLK | Per-clock enable failure report |
| dbg_in | input | DBG_W | Debug word captured on link timeout |
| phy_pd | output | 1 | PHY test power-down |
| refclk_en | output | 1 | Reference-clock enable |
| ep_rst_n | output | 1 | Endpoint reset, active low |
| slot_pwr_en | output | 1 | Slot power enable (tied low when HAS_SLOT_PWR is 0) |
| clk_en | output | NCLK | Per-clock enables |
| train_en | output | 1 | Link training enable |
| dev_type | output | 4 | Device-type field |
| los_level | output | 6 | Loss-of-signal level |
| tx_deemph_g1 | output | 6 | Gen1 de-emphasis |
| tx_deemph_g2_35 | output | 6 | Gen2 3.5 dB de-emphasis |
| tx_deemph_g2_6 | output | 6 | Gen2 6 dB de-emphasis |
| tx_swing_full | output | 7 | Full transmit swing |
| tx_swing_low | output | 7 | Low transmit swing |
| busy | output | 1 | Programme in progress |
| done | output | 1 | Link came up |
| fail | output | 1 | Programme ended in error |
| err_code | output | 2 | 0 none, 1 clock error, 2 link timeout |
| fail_clk | output | $clog2(NCLK) | Index of the clock that reported an error |
| dbg_snap | output | DBG_W | Debug word captured on link timeout |

## Verification
Some ordering rules are checked on every cycle. The endpoint reset may only fall while the PHY is powered down with its reference clock off. A clock enable may only be on while the reference clock runs. Clock enables rise only above a fully enabled lower range and fall only from the top. Done, and the raised training enable, always see the full settings and clock set. The exact cycle of each step can only be shown by the bench's scenarios, which compare every output against the bench model on every cycle. These include the length of the endpoint reset pulse and of the settle wait, the poll spacing and the point of timeout, the unwinding after a failed clock at index 2 and at index 0, and a start pulse during a run having no effect.

// File: rtl/bup_pkg.sv
package bup_pkg;

    localparam logic [3:0] DEV_TYPE_ROOT = 4'd4;
    localparam logic [5:0] LOS_LEVEL_DEF = 6'd9;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_CLK  = 2'd1,
        ERR_LINK = 2'd2
    } err_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PD_ON,
        ST_TRN_HI,
        ST_REF_OFF,
        ST_EP_LO,
        ST_EP_WAIT,
        ST_TRN_LO,
        ST_CFG,
        ST_SLOT,
        ST_PD_OFF,
        ST_REF_ON,
        ST_CLK_ON,
        ST_CLK_CHK,
        ST_UNWIND,
        ST_SETTLE,
        ST_POLL,
        ST_DONE,
        ST_FAIL
    } state_e;

    typedef struct packed {
        logic [3:0] dev_type;
        logic [5:0] los_level;
        logic [5:0] deemph_g1;
        logic [5:0] deemph_g2_35;
        logic [5:0] deemph_g2_6;
        logic [6:0] swing_full;
        logic [6:0] swing_low;
    } phy_cfg_t;

    function automatic phy_cfg_t root_port_cfg();
        phy_cfg_t c;
        c.dev_type     = DEV_TYPE_ROOT;
        c.los_level    = LOS_LEVEL_DEF;
        c.deemph_g1    = 6'd0;
        c.deemph_g2_35 = 6'd0;
        c.deemph_g2_6  = 6'd20;
        c.swing_full   = 7'd127;
        c.swing_low    = 7'd127;
        return c;
    endfunction

    function automatic logic is_wait(state_e s);
        return (s == ST_EP_WAIT) || (s == ST_SETTLE) || (s == ST_POLL);
    endfunction

    function automatic logic is_active(state_e s);
        return !((s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL));
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bup_tick_timer.sv
module bup_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         hit
);

    logic [W-1:0] cnt_q;

    assign hit = run && (cnt_q == target);

    always_ff @(posedge clk) begin
        if (rst || !run || hit) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bup_clk_bank.sv
module bup_clk_bank #(
    parameter int NCLK = 4,
    parameter int IW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_all,
    input  logic            set_en,
    input  logic            drop_en,
    input  logic [IW-1:0]   idx,
    output logic [NCLK-1:0] en
);

    for (genvar g = 0; g < NCLK; g++) begin : g_bit
        logic sel;
        assign sel = (idx == IW'(g));
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                en[g] <= 1'b0;
            end else if (set_en && sel) begin
                en[g] <= 1'b1;
            end else if (drop_en && sel) begin
                en[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bup_phy_cfg_reg.sv
module bup_phy_cfg_reg
    import bup_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    output phy_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (load) begin
            cfg <= root_port_cfg();
        end
    end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import bup_pkg::*;
#(
    parameter int NCLK         = 4,
    parameter int EP_RST_US    = 10,
    parameter int SETTLE_US    = 200,
    parameter int POLL_US      = 100,
    parameter int MAX_POLLS    = 8,
    parameter int HAS_SLOT_PWR = 1,
    parameter int DBG_W        = 32,
    localparam int IW          = (NCLK > 1) ? $clog2(NCLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             link_up,
    input  logic             us_tick,
    input  logic [NCLK-1:0]  clk_err,
    input  logic [DBG_W-1:0] dbg_in,
    output logic             phy_pd,
    output logic             refclk_en,
    output logic             ep_rst_n,
    output logic             slot_pwr_en,
    output logic [NCLK-1:0]  clk_en,
    output logic             train_en,
    output logic [3:0]       dev_type,
    output logic [5:0]       los_level,
    output logic [5:0]       tx_deemph_g1,
    output logic [5:0]       tx_deemph_g2_35,
    output logic [5:0]       tx_deemph_g2_6,
    output logic [6:0]       tx_swing_full,
    output logic [6:0]       tx_swing_low,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [1:0]       err_code,
    output logic [IW-1:0]    fail_clk,
    output logic [DBG_W-1:0] dbg_snap
);

    localparam int TMR_MAX = max3(EP_RST_US, SETTLE_US, POLL_US);
    localparam int TW      = $clog2(TMR_MAX + 1);
    localparam int PW      = $clog2(MAX_POLLS + 1);
    localparam logic [IW-1:0] LAST_IDX  = IW'(NCLK - 1);
    localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

    state_e           state_q;
    logic [IW-1:0]    idx_q;
    logic [PW-1:0]    polls_q;
    logic             pd_q, ref_q, ep_q, slot_q, train_q;
    logic             done_q, fail_q;
    err_e             err_q;
    logic [IW-1:0]    fail_clk_q;
    logic [DBG_W-1:0] snap_q;

    logic             seq_go;
    logic             tmr_run, tmr_hit;
    logic [TW-1:0]    tmr_target;
    phy_cfg_t         cfg;

    assign seq_go  = start && !is_active(state_q);
    assign tmr_run = is_wait(state_q);

    always_comb begin
        case (state_q)
            ST_EP_WAIT: tmr_target = TW'(EP_RST_US);
            ST_SETTLE:  tmr_target = TW'(SETTLE_US);
            default:    tmr_target = TW'(POLL_US);
        endcase
    end

    bup_tick_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (tmr_run),
        .tick   (us_tick),
        .target (tmr_target),
        .hit    (tmr_hit)
    );

    bup_clk_bank #(.NCLK(NCLK), .IW(IW)) u_clks (
        .clk     (clk),
        .rst     (rst),
        .clr_all (seq_go),
        .set_en  (state_q == ST_CLK_ON),
        .drop_en (state_q == ST_UNWIND),
        .idx     (idx_q),
        .en      (clk_en)
    );

    bup_phy_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (state_q == ST_CFG),
        .cfg  (cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            polls_q    <= '0;
            pd_q       <= 1'b1;
            ref_q      <= 1'b0;
            ep_q       <= 1'b1;
            slot_q     <= 1'b0;
            train_q    <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            err_q      <= ERR_NONE;
            fail_clk_q <= '0;
            snap_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        err_q   <= ERR_NONE;
                        idx_q   <= '0;
                        state_q <= ST_PD_ON;
                    end
                end
                ST_PD_ON: begin
                    pd_q    <= 1'b1;
                    state_q <= ST_TRN_HI;
                end
                ST_TRN_HI: begin
                    train_q <= 1'b1;
                    state_q <= ST_REF_OFF;
                end
                ST_REF_OFF: begin
                    ref_q   <= 1'b0;
                    state_q <= ST_EP_LO;
                end
                ST_EP_LO: begin
                    ep_q    <= 1'b0;
                    state_q <= ST_EP_WAIT;
                end
                ST_EP_WAIT: begin
                    if (tmr_hit) begin
                        ep_q    <= 1'b1;
                        state_q <= ST_TRN_LO;
                    end
                end
                ST_TRN_LO: begin
                    train_q <= 1'b0;
                    state_q <= ST_CFG;
                end
                ST_CFG: begin
                    state_q <= ST_SLOT;
                end
                ST_SLOT: begin
                    slot_q  <= (HAS_SLOT_PWR != 0);
                    state_q <= ST_PD_OFF;
                end
                ST_PD_OFF: begin
                    pd_q    <= 1'b0;
                    state_q <= ST_REF_ON;
                end
                ST_REF_ON: begin
                    ref_q   <= 1'b1;
                    idx_q   <= '0;
                    state_q <= ST_CLK_ON;
                end
                ST_CLK_ON: begin
                    state_q <= ST_CLK_CHK;
                end
                ST_CLK_CHK: begin
                    if (clk_err[idx_q]) begin
                        fail_clk_q <= idx_q;
                        state_q    <= ST_UNWIND;
                    end else if (idx_q == LAST_IDX) begin
                        state_q <= ST_SETTLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_CLK_ON;
                    end
                end
                ST_UNWIND: begin
                    if (idx_q == '0) begin
                        fail_q  <= 1'b1;
                        err_q   <= ERR_CLK;
                        state_q <= ST_FAIL;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_hit) begin
                        train_q <= 1'b1;
                        polls_q <= '0;
                        state_q <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (tmr_hit) begin
                        if (link_up) begin
                            done_q  <= 1'b1;
                            state_q <= ST_DONE;
                        end else if (polls_q == LAST_POLL) begin
                            fail_q  <= 1'b1;
                            err_q   <= ERR_LINK;
                            snap_q  <= dbg_in;
                            state_q <= ST_FAIL;
                        end else begin
                            polls_q <= polls_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    if (HAS_SLOT_PWR != 0) begin : g_slot
        assign slot_pwr_en = slot_q;
    end else begin : g_no_slot
        assign slot_pwr_en = 1'b0;
    end

    assign phy_pd          = pd_q;
    assign refclk_en       = ref_q;
    assign ep_rst_n        = ep_q;
    assign train_en        = train_q;
    assign dev_type        = cfg.dev_type;
    assign los_level       = cfg.los_level;
    assign tx_deemph_g1    = cfg.deemph_g1;
    assign tx_deemph_g2_35 = cfg.deemph_g2_35;
    assign tx_deemph_g2_6  = cfg.deemph_g2_6;
    assign tx_swing_full   = cfg.swing_full;
    assign tx_swing_low    = cfg.swing_low;
    assign busy            = is_active(state_q);
    assign done            = done_q;
    assign fail            = fail_q;
    assign err_code        = err_q;
    assign fail_clk        = fail_clk_q;
    assign dbg_snap        = snap_q;

endmodule

// File: rtl/bup_seq_checker.sv
module bup_seq_checker
    import bup_pkg::*;
#(
    parameter int NCLK = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            phy_pd,
    input logic            refclk_en,
    input logic            ep_rst_n,
    input logic [NCLK-1:0] clk_en,
    input logic            train_en,
    input logic [3:0]      dev_type,
    input logic [5:0]      los_level,
    input logic            done,
    input logic            fail,
    input logic [1:0]      err_code
);

    AST_EP_LOW_SAFE: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_rst_n) |-> (phy_pd && !refclk_en)); // R1

    AST_CFG_BEFORE_TRAIN: assert property (@(posedge clk) disable iff (rst)
        ($rose(train_en) && (&clk_en)) |-> (dev_type == DEV_TYPE_ROOT && los_level == LOS_LEVEL_DEF)); // R2

    AST_CLK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        (clk_en != '0) |-> (refclk_en && !phy_pd)); // R3

    for (genvar i = 1; i < NCLK; i++) begin : g_order
        AST_CLK_RISE_ORDER: assert property (@(posedge clk) disable iff (rst)
            $rose(clk_en[i]) |-> (&clk_en[i-1:0])); // R4
    end

    for (genvar i = 0; i < NCLK; i++) begin : g_unwind
        AST_CLK_FALL_TOP: assert property (@(posedge clk) disable iff (rst)
            $fell(clk_en[i]) |-> (clk_en[NCLK-1:i] == '0)); // R8
    end

    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> (train_en && (&clk_en) && refclk_en && !phy_pd && ep_rst_n)); // R6

    AST_CLK_FAIL_OFF: assert property (@(posedge clk) disable iff (rst)
        (fail && err_code == 2'd1) |-> (clk_en == '0 && !train_en)); // R8

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fail)); // R11

endmodule

bind link_bringup_seq bup_seq_checker #(.NCLK(NCLK)) u_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .phy_pd    (phy_pd),
    .refclk_en (refclk_en),
    .ep_rst_n  (ep_rst_n),
    .clk_en    (clk_en),
    .train_en  (train_en),
    .dev_type  (dev_type),
    .los_level (los_level),
    .done      (done),
    .fail      (fail),
    .err_code  (err_code)
);

// File: tb/link_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module link_bringup_seq_tb_top;

    localparam int NCLK      = 4;
    localparam int EP_RST_US = 10;
    localparam int SETTLE_US = 200;
    localparam int POLL_US   = 100;
    localparam int MAX_POLLS = 8;
    localparam int DBG_W     = 32;
    localparam int IW        = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic link_up = 1'b0;
    logic us_tick = 1'b0;
    logic [NCLK-1:0] clk_err = '0;
    logic [DBG_W-1:0] dbg_in = 32'h1000_0000;

    logic phy_pd, refclk_en, ep_rst_n, slot_pwr_en, train_en, busy, done, fail;
    logic [NCLK-1:0] clk_en;
    logic [3:0] dev_type;
    logic [5:0] los_level, tx_deemph_g1, tx_deemph_g2_35, tx_deemph_g2_6;
    logic [6:0] tx_swing_full, tx_swing_low;
    logic [1:0] err_code;
    logic [IW-1:0] fail_clk;
    logic [DBG_W-1:0] dbg_snap;

    int total = 0;
    int failed = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    link_bringup_seq #(
        .NCLK(NCLK), .EP_RST_US(EP_RST_US), .SETTLE_US(SETTLE_US),
        .POLL_US(POLL_US), .MAX_POLLS(MAX_POLLS), .HAS_SLOT_PWR(1), .DBG_W(DBG_W)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .link_up(link_up), .us_tick(us_tick),
        .clk_err(clk_err), .dbg_in(dbg_in),
        .phy_pd(phy_pd), .refclk_en(refclk_en), .ep_rst_n(ep_rst_n),
        .slot_pwr_en(slot_pwr_en), .clk_en(clk_en), .train_en(train_en),
        .dev_type(dev_type), .los_level(los_level), .tx_deemph_g1(tx_deemph_g1),
        .tx_deemph_g2_35(tx_deemph_g2_35), .tx_deemph_g2_6(tx_deemph_g2_6),
        .tx_swing_full(tx_swing_full), .tx_swing_low(tx_swing_low),
        .busy(busy), .done(done), .fail(fail), .err_code(err_code),
        .fail_clk(fail_clk), .dbg_snap(dbg_snap)
    );

    // expected outputs, reset values (R10)
    logic e_pd = 1, e_ref = 0, e_ep = 1, e_slot = 0, e_train = 0;
    logic e_busy = 0, e_done = 0, e_fail = 0;
    logic [NCLK-1:0] e_clk = '0;
    logic [3:0] e_dev = 0;
    logic [5:0] e_los = 0, e_g1 = 0, e_g235 = 0, e_g26 = 0;
    logic [6:0] e_full = 0, e_low = 0;
    logic [1:0] e_err = 0;
    logic [IW-1:0] e_fclk = 0;
    logic [DBG_W-1:0] e_snap = 0;

    task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    // microsecond tick every third cycle and a moving debug word
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div++;
            us_tick = (div % 3 == 0);
            dbg_in = dbg_in + 32'h0001_0003;
        end
    end

    // reference model: a timeline of expected output changes
    task automatic wait_ticks(input int n);
        int c = 0;
        forever begin
            @(posedge clk);
            if (c == n) break;
            if (us_tick) c++;
        end
    endtask

    task automatic model_run();
        e_busy = 1; e_done = 0; e_fail = 0; e_err = 0; e_clk = '0;
        @(posedge clk); e_pd = 1;
        @(posedge clk); e_train = 1;
        @(posedge clk); e_ref = 0;
        @(posedge clk); e_ep = 0;
        wait_ticks(EP_RST_US); e_ep = 1;
        @(posedge clk); e_train = 0;
        @(posedge clk);
        e_dev = 4; e_los = 9; e_g1 = 0; e_g235 = 0; e_g26 = 20; e_full = 127; e_low = 127;
        @(posedge clk); e_slot = 1;
        @(posedge clk); e_pd = 0;
        @(posedge clk); e_ref = 1;
        for (int i = 0; i < NCLK; i++) begin
            @(posedge clk); e_clk[i] = 1'b1;
            @(posedge clk);
            if (clk_err[i]) begin
                e_fclk = IW'(i);
                for (int j = i; j >= 0; j--) begin
                    @(posedge clk); e_clk[j] = 1'b0;
                end
                e_fail = 1; e_err = 1; e_busy = 0;
                return;
            end
        end
        wait_ticks(SETTLE_US); e_train = 1;
        for (int p = 0; p < MAX_POLLS; p++) begin
            wait_ticks(POLL_US);
            if (link_up) begin
                e_done = 1; e_busy = 0;
                return;
            end
            if (p == MAX_POLLS - 1) begin
                e_fail = 1; e_err = 2; e_snap = dbg_in; e_busy = 0;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (!rst && start) model_run();
        end
    end

    // compare every output on every cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk("R1", "phy_pd", 32'(phy_pd), 32'(e_pd));
            chk("R1", "ep_rst_n", 32'(ep_rst_n), 32'(e_ep));
            chk("R3", "refclk_en", 32'(refclk_en), 32'(e_ref));
            chk("R3", "slot_pwr_en", 32'(slot_pwr_en), 32'(e_slot));
            chk("R4", "clk_en", 32'(clk_en), 32'(e_clk));
            chk("R5", "train_en", 32'(train_en), 32'(e_train));
            chk("R2", "cfg", {dev_type, los_level, tx_deemph_g1, tx_deemph_g2_35, tx_deemph_g2_6},
                {e_dev, e_los, e_g1, e_g235, e_g26});
            chk("R2", "swing", {18'd0, tx_swing_full, tx_swing_low}, {18'd0, e_full, e_low});
            chk("R11", "busy", 32'(busy), 32'(e_busy));
            chk("R6", "done", 32'(done), 32'(e_done));
            chk("R11", "fail", 32'(fail), 32'(e_fail));
            chk("R7", "err_code", 32'(err_code), 32'(e_err));
            chk("R8", "fail_clk", 32'(fail_clk), 32'(e_fclk));
            chk("R7", "dbg_snap", dbg_snap, e_snap);
            chk("R11", "done_fail_excl", 32'(done && fail), 32'd0);
        end
    end

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        while (e_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10", "reset pd", 32'(phy_pd), 32'd1);
        chk("R10", "reset ref", 32'(refclk_en), 32'd0);
        chk("R10", "reset ep", 32'(ep_rst_n), 32'd1);
        chk("R10", "reset clk", 32'(clk_en), 32'd0);
        chk("R10", "reset status", {29'd0, busy, done, fail}, 32'd0);

        // success after a few polls, with a start pulse mid-run (R9)
        go();
        repeat (6) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R9", "busy after ignored start", 32'(busy), 32'd1);
        chk("R9", "ep held low", 32'(ep_rst_n), 32'd0);
        while (!(e_train && e_clk == 4'hF)) @(negedge clk);
        repeat (700) @(negedge clk);
        link_up = 1'b1;
        wait_idle();
        chk("R6", "done after link", 32'(done), 32'd1);
        chk("R6", "clocks all on", 32'(clk_en), 32'hF);
        link_up = 1'b0;

        // clock 2 reports error (R8)
        clk_err = 4'b0100;
        go();
        wait_idle();
        chk("R8", "clk fail flag", 32'(fail), 32'd1);
        chk("R8", "clk fail code", 32'(err_code), 32'd1);
        chk("R8", "clk fail idx", 32'(fail_clk), 32'd2);
        chk("R8", "clocks off", 32'(clk_en), 32'd0);
        clk_err = '0;

        // link timeout from fail state (R7, R9)
        go();
        wait_idle();
        chk("R7", "timeout code", 32'(err_code), 32'd2);
        chk("R7", "snapshot", dbg_snap, e_snap);

        // clock 0 reports error
        clk_err = 4'b0001;
        go();
        wait_idle();
        chk("R8", "clk0 fail idx", 32'(fail_clk), 32'd0);
        chk("R8", "clk0 code", 32'(err_code), 32'd1);
        clk_err = '0;

        // link already up: done at first poll
        link_up = 1'b1;
        go();
        wait_idle();
        chk("R6", "immediate done", 32'(done), 32'd1);
        chk("R2", "los level", 32'(los_level), 32'd9);
        summary();
    end

endmodule